// File: doc/BRIEF.md
# Dual-Address Receive Frame Filter

This block sits between an infrared frame receiver and its receive FIFO. The receiver delivers a byte stream in which a start-of-frame pulse and an end-of-frame pulse mark each frame. The filter treats the first byte of each frame as its address. It then either forwards the whole frame to the FIFO through a write strobe, or drops it without a single write.

Two programmable addresses each have their own enable bit. Each enabled address acts as one member of a private/public pair, and a frame whose address byte equals any enabled address is accepted. When every enable is clear, filtering is off and all frames pass. The addresses and enables are captured when a frame starts. Changing them in the middle of a frame therefore does not alter how that frame is handled.

With the default registered output, each forwarded byte appears on the FIFO side exactly one clock after it entered.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fifo_wr` is 0 and `fifo_data` is 0.
- R2: With every bit of `cfg_en` clear, every byte from a start-of-frame up to and including the byte that carries end-of-frame is written, unchanged and in order.
- R3: With only `cfg_en[0]` set, a frame whose address byte equals `cfg_addr[7:0]` is forwarded whole, address byte included.
- R4: With only `cfg_en[1]` set, a frame whose address byte equals `cfg_addr[15:8]` is forwarded whole.
- R5: With both enable bits set, a frame is accepted when its address byte equals either programmed address.
- R6: With at least one enable set, a frame whose address byte matches no enabled address produces no write for any of its bytes.
- R7: Changes to `cfg_en` or `cfg_addr` after a start-of-frame do not change the handling of that frame. They apply from the next start-of-frame.
- R8: A start-of-frame that arrives inside a frame ends that frame. The next byte is then evaluated as a new address.
- R9: Bytes that arrive after end-of-frame and before the next start-of-frame are never written.
- R10: A byte presented in the same cycle as `in_sof` is that frame's address byte. A byte presented with `in_eof` is the frame's last byte and is forwarded if the frame is accepted.
- R11: With the default registered output, `fifo_wr` is raised in the cycle after the accepted input byte, and `fifo_data` equals that byte. `fifo_data` holds its value between writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sof | input | 1 | Start-of-frame pulse |
| in_eof | input | 1 | End-of-frame pulse; a byte in the same cycle is the last byte |
| in_valid | input | 1 | `in_data` carries a received byte |
| in_data | input | 8 | Received byte |
| cfg_addr | input | 16 | Address 0 in [7:0], address 1 in [15:8] |
| cfg_en | input | 2 | Enable for address 0 in bit 0, for address 1 in bit 1 |
| fifo_wr | output | 1 | Write strobe toward the receive FIFO |
| fifo_data | output | 8 | Byte to be written |

## Verification
A wrong accept flag or phase shows up at the FIFO port one cycle after the first body byte, as a missing write or an extra one. A stale configuration snapshot shows up on the address byte of the following frame. The bench runs a behavioural model alongside the design and compares it every clock, so any divergence is reported in the cycle it appears. Per-frame write counts confirm the whole-frame result for each scenario.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_BODY = 2'd2
   } phase_t;
endpackage

// File: rtl/raf_cfg_snap.sv
module raf_cfg_snap #(
   parameter int AW     = 8,
   parameter int N_ADDR = 2,
   localparam int TW    = AW * N_ADDR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof,
   input  logic [TW-1:0]     live_addr,
   input  logic [N_ADDR-1:0] live_en,
   output logic [TW-1:0]     eff_addr,
   output logic [N_ADDR-1:0] eff_en
);
   logic [TW-1:0]     snap_addr;
   logic [N_ADDR-1:0] snap_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_addr <= '0;
         snap_en   <= '0;
      end else if (sof) begin
         snap_addr <= live_addr;
         snap_en   <= live_en;
      end
   end

   // A byte that arrives with sof uses the values being captured now.
   assign eff_addr = sof ? live_addr : snap_addr;
   assign eff_en   = sof ? live_en   : snap_en;
endmodule

// File: rtl/raf_addr_match.sv
module raf_addr_match #(
   parameter int AW     = 8,
   parameter int N_ADDR = 2,
   localparam int TW    = AW * N_ADDR
) (
   input  logic [AW-1:0]     byte_in,
   input  logic [TW-1:0]     addr,
   input  logic [N_ADDR-1:0] en,
   output logic              accept
);
   logic [N_ADDR-1:0] hit;

   for (genvar i = 0; i < N_ADDR; i++) begin : g_cmp
      assign hit[i] = en[i] && (byte_in == addr[i*AW +: AW]);
   end

   assign accept = (en == '0) || (|hit);
endmodule

// File: rtl/raf_seq.sv
module raf_seq
   import rx_addr_filter_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sof,
   input  logic eof,
   input  logic valid,
   input  logic accept_in,
   output logic wr_next
);
   phase_t phase_q, phase_now, phase_d;
   logic   acc_q, acc_d;

   always_comb begin
      phase_now = sof ? PH_ADDR : phase_q;
      wr_next   = 1'b0;
      phase_d   = phase_now;
      acc_d     = acc_q;
      if (valid) begin
         unique case (phase_now)
            PH_ADDR: begin
               wr_next = accept_in;
               acc_d   = accept_in;
               phase_d = PH_BODY;
            end
            PH_BODY: wr_next = acc_q;
            default: wr_next = 1'b0;
         endcase
      end
      if (eof) phase_d = PH_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         acc_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         acc_q   <= acc_d;
      end
   end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
   parameter int AW      = 8,
   parameter int N_ADDR  = 2,
   parameter bit OUT_REG = 1'b1,
   localparam int TW     = AW * N_ADDR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic              in_valid,
   input  logic [AW-1:0]     in_data,
   input  logic [TW-1:0]     cfg_addr,
   input  logic [N_ADDR-1:0] cfg_en,
   output logic              fifo_wr,
   output logic [AW-1:0]     fifo_data
);
   if (AW < 1) begin : g_bad_aw
      $error("rx_addr_filter: AW must be at least 1");
   end
   if (N_ADDR < 1) begin : g_bad_n
      $error("rx_addr_filter: N_ADDR must be at least 1");
   end

   logic [TW-1:0]     eff_addr;
   logic [N_ADDR-1:0] eff_en;
   logic              accept;
   logic              wr_next;

   raf_cfg_snap #(.AW(AW), .N_ADDR(N_ADDR)) u_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof       (in_sof),
      .live_addr (cfg_addr),
      .live_en   (cfg_en),
      .eff_addr  (eff_addr),
      .eff_en    (eff_en)
   );

   raf_addr_match #(.AW(AW), .N_ADDR(N_ADDR)) u_match (
      .byte_in (in_data),
      .addr    (eff_addr),
      .en      (eff_en),
      .accept  (accept)
   );

   raf_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .sof       (in_sof),
      .eof       (in_eof),
      .valid     (in_valid),
      .accept_in (accept),
      .wr_next   (wr_next)
   );

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
         end else begin
            fifo_wr <= wr_next;
            if (wr_next) fifo_data <= in_data;
         end
      end
   end else begin : g_comb_out
      assign fifo_wr   = wr_next;
      assign fifo_data = in_data;
   end
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
   parameter int AW      = 8,
   parameter int N_ADDR  = 2,
   parameter bit OUT_REG = 1'b1,
   localparam int TW     = AW * N_ADDR
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_sof,
   input logic              in_eof,
   input logic              in_valid,
   input logic [AW-1:0]     in_data,
   input logic [TW-1:0]     cfg_addr,
   input logic [N_ADDR-1:0] cfg_en,
   input logic              fifo_wr,
   input logic [AW-1:0]     fifo_data
);
   logic open_q;
   logic any_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_q <= 1'b0;
      else        open_q <= (in_sof || open_q) && !in_eof;
   end

   always_comb begin
      any_hit = 1'b0;
      for (int i = 0; i < N_ADDR; i++)
         if (cfg_en[i] && in_data == cfg_addr[i*AW +: AW]) any_hit = 1'b1;
   end

   if (OUT_REG) begin : g_reg_props
      // R1
      reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !fifo_wr);
      // R11
      write_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fifo_wr |-> $past(in_valid) && fifo_data == $past(in_data));
      // R2
      open_filter_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_sof && in_valid && cfg_en == '0 |=> fifo_wr);
      // R5
      match_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_sof && in_valid && any_hit |=> fifo_wr);
      // R6
      miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_sof && in_valid && cfg_en != '0 && !any_hit |=> !fifo_wr);
      // R9
      outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && !in_sof && !open_q |=> !fifo_wr);
   end
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.AW(AW), .N_ADDR(N_ADDR), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_sof    (in_sof),
   .in_eof    (in_eof),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .cfg_addr  (cfg_addr),
   .cfg_en    (cfg_en),
   .fifo_wr   (fifo_wr),
   .fifo_data (fifo_data)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_sof = 1'b0, in_eof = 1'b0, in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic [15:0] cfg_addr = 16'h0000;
   logic [1:0]  cfg_en = 2'b00;
   logic        fifo_wr;
   logic [7:0]  fifo_data;

   int checks = 0, failures = 0, wr_cnt = 0;
   bit done = 1'b0;
   string cur = "R1";

   always #4 clk = ~clk;

   rx_addr_filter u0 (
      .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .in_eof(in_eof),
      .in_valid(in_valid), .in_data(in_data), .cfg_addr(cfg_addr),
      .cfg_en(cfg_en), .fifo_wr(fifo_wr), .fifo_data(fifo_data)
   );

   // Behavioural reference model
   bit       m_open = 0, m_first = 0, m_acc = 0;
   bit [7:0] m_a0 = 0, m_a1 = 0;
   bit [1:0] m_en = 0;
   bit       exp_wr = 0;
   bit [7:0] exp_data = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_open = 0; m_first = 0; m_acc = 0; exp_wr = 0; exp_data = 0;
      end else begin
         exp_wr = 0;
         if (in_sof) begin
            m_a0 = cfg_addr[7:0]; m_a1 = cfg_addr[15:8]; m_en = cfg_en;
            m_open = 1; m_first = 1;
         end
         if (in_valid && m_open) begin
            if (m_first) begin
               m_first = 0;
               if (m_en == 2'b00) m_acc = 1;
               else m_acc = (m_en[0] && in_data == m_a0) || (m_en[1] && in_data == m_a1);
            end
            if (m_acc) begin
               exp_wr = 1; exp_data = in_data;
            end
         end
         if (in_eof) m_open = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (fifo_wr !== exp_wr || fifo_data !== exp_data) begin
            failures++;
            $display("FAIL R11 (%s) cycle compare: wr=%0b data=%02h expected wr=%0b data=%02h",
                     cur, fifo_wr, fifo_data, exp_wr, exp_data);
         end
         if (fifo_wr) wr_cnt++;
      end
   end

   task automatic cyc(input bit s, input bit e, input bit v, input logic [7:0] d);
      in_sof = s; in_eof = e; in_valid = v; in_data = d;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00);
   endtask

   task automatic frame(input logic [7:0] a, input int nbody);
      cyc(1, 0, 0, 8'h00);
      cyc(0, nbody == 0, 1, a);
      for (int i = 0; i < nbody; i++) cyc(0, i == nbody - 1, 1, 8'hA0 + 8'(i));
   endtask

   task automatic expect_count(input string req, input int exp);
      idle(2);
      checks++;
      if (wr_cnt != exp) begin
         failures++;
         $display("FAIL %s write count: actual %0d expected %0d", req, wr_cnt, exp);
      end
      wr_cnt = 0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual hung expected completion");
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      checks++;   // R1 during reset
      if (fifo_wr !== 1'b0 || fifo_data !== 8'h00) begin
         failures++;
         $display("FAIL R1 reset: wr=%0b data=%02h expected wr=0 data=00", fifo_wr, fifo_data);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;   // R1 first cycle after reset
      if (fifo_wr !== 1'b0 || fifo_data !== 8'h00) begin
         failures++;
         $display("FAIL R1 after reset: wr=%0b data=%02h expected wr=0 data=00", fifo_wr, fifo_data);
      end
      wr_cnt = 0;

      cfg_addr = 16'hC35A;
      cur = "R2"; cfg_en = 2'b00; frame(8'h11, 3); expect_count("R2", 4);
      cur = "R3"; cfg_en = 2'b01; frame(8'h5A, 2); expect_count("R3", 3);
      cur = "R6"; frame(8'hC3, 2); expect_count("R6", 0);
      cur = "R4"; cfg_en = 2'b10; frame(8'hC3, 1); expect_count("R4", 2);
      cur = "R6"; frame(8'h5A, 1); expect_count("R6", 0);
      cur = "R5"; cfg_en = 2'b11; frame(8'h5A, 2); expect_count("R5", 3);
      frame(8'hC3, 3); expect_count("R5", 4);
      cur = "R6"; frame(8'h77, 3); expect_count("R6", 0);

      // R7: accepted frame, config changed after its address
      cur = "R7"; cfg_en = 2'b01;
      cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h5A);
      cfg_en = 2'b10; cfg_addr = 16'h0000;
      cyc(0, 0, 1, 8'h01); cyc(0, 1, 1, 8'h02);
      expect_count("R7", 3);
      // R7: dropped frame, filtering opened mid-frame
      cfg_en = 2'b01; cfg_addr = 16'hC35A;
      cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h99);
      cfg_en = 2'b00;
      cyc(0, 0, 1, 8'h03); cyc(0, 1, 1, 8'h04);
      expect_count("R7", 0);
      // R7: new config applies at next sof
      frame(8'h99, 1); expect_count("R7", 2);

      // R8: sof in the middle of a dropped frame
      cur = "R8"; cfg_en = 2'b01;
      cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h99); cyc(0, 0, 1, 8'h05);
      cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h5A); cyc(0, 0, 1, 8'h06); cyc(0, 1, 1, 8'h07);
      expect_count("R8", 3);
      // R8: sof in the middle of an accepted frame restarts with a miss
      cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h5A); cyc(0, 0, 1, 8'h08);
      cyc(1, 0, 0, 0); cyc(0, 0, 1, 8'h33); cyc(0, 1, 1, 8'h09);
      expect_count("R8", 2);

      // R9: stray bytes between frames
      cur = "R9"; cfg_en = 2'b00;
      frame(8'h5A, 0); cyc(0, 0, 1, 8'hEE); cyc(0, 0, 1, 8'hEF);
      expect_count("R9", 1);

      // R10: byte with sof is the address; byte with eof is forwarded
      cur = "R10"; cfg_en = 2'b01;
      cyc(1, 0, 1, 8'h5A); cyc(0, 1, 1, 8'h0A);
      expect_count("R10", 2);
      cyc(1, 1, 1, 8'h5A); expect_count("R10", 1);
      cyc(1, 0, 1, 8'h44); cyc(0, 1, 1, 8'h0B); expect_count("R10", 0);

      // R11: exact latency and data hold
      cur = "R11"; cfg_en = 2'b00;
      cyc(1, 0, 1, 8'h6C);
      checks++;
      if (fifo_wr !== 1'b1 || fifo_data !== 8'h6C) begin
         failures++;
         $display("FAIL R11 latency: wr=%0b data=%02h expected wr=1 data=6c", fifo_wr, fifo_data);
      end
      cyc(0, 1, 0, 8'h00);
      checks++;
      if (fifo_wr !== 1'b0 || fifo_data !== 8'h6C) begin
         failures++;
         $display("FAIL R11 hold: wr=%0b data=%02h expected wr=0 data=6c", fifo_wr, fifo_data);
      end
      idle(2);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule